// File: doc/BRIEF.md
# Expansion Card Autoconfiguration Responder

This block is the configuration logic of a plug-in card on a 24-bit address, 16-bit data expansion bus. Cards are daisy-chained by an enable signal. While its incoming enable is high and it has not yet been configured, the card answers at a fixed configuration window at 0xE80000. Host software reads the card's identity and requirements there, one 4-bit value per 16-bit register on data lines D15..D12. The fields are maker, product, board type, size, whether the board can be told to disappear, whether a diagnostic ROM is present, and whether another on-card board follows.

Host software then writes a base address. The card moves its decode to that base, leaves the configuration window, and raises its outgoing enable so that the next card appears. Software can also send a disappear command. The card then stops answering entirely but still passes the enable on. A card can hold several sub-boards in a chain on the card. Each sub-board configures in turn, and only the last one drives the card's outgoing enable.

The bus here is a simplified synchronous one. The address is a word address, and a one-cycle read or write strobe is sampled on the clock. Every response is registered.

Top module: `expansion_autoconfig`

## Requirements
- R1: A sub-board answers (asserts `ack`) at the window 0xE80000..0xE8FFFF only while its incoming enable is high and it is neither configured nor shut up. Otherwise an access there gets no `ack` and `rdata` is zero.
- R2: Identity reads return a nibble on `rdata[15:12]` with `rdata[11:0]` zero. The registers sit at byte offsets 0x00, 0x02, and so on. Offset 0x00 holds {type[1:0], diag, chained} uninverted. Offset 0x02 holds ~{shutup_capable, size[2:0]}. Offsets 0x04 and 0x06 hold the inverted product high and low nibbles. Offsets 0x08..0x0E hold the inverted maker nibbles, most significant first.
- R3: The size code is (log2(window bytes) − 15) mod 8, so a 64 KB window reports 1.
- R4: A write at byte offset 0x48 stores `wdata_hi` as the low base nibble only. The sub-board keeps answering in the configuration window and the outgoing enable stays low.
- R5: A write at byte offset 0x4A takes `wdata_hi` as the high base nibble and commits base = {high, low}, which are address bits A23..A16. From the next cycle the sub-board stops answering the configuration window. `fn_sel[i]` pulses for accesses whose A23..A(log2 size) equal the base.
- R6: Committing the base, or shutting up, raises the sub-board's outgoing enable in the same cycle that its state changes. Sub-board i+1 is enabled by sub-board i. `cfg_out` is the last sub-board's enable. The chained bit reads 1 on every sub-board except the last.
- R7: On a shut-up-capable sub-board, a write at byte offset 0x4C before configuration disables all of its decode until reset and raises its outgoing enable.
- R8: Synchronous active-high reset clears the configured and shut-up state, drops `cfg_out`, and zeroes `ack`, `rdata` and `fn_sel`.
- R9: Responses are registered. `ack`, `rdata` and `fn_sel` reflect the access strobed at one rising edge from that edge until the next one, and writes in the configuration window are also acknowledged.
- R10: A read at an unmapped offset of the configuration window is acknowledged and returns a zero nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in | input | 1 | Chain enable from the previous slot |
| addr | input | ADDR_W-1 | Word address A23..A1 |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata_hi | input | 4 | Write data lines D15..D12 |
| rdata | output | 16 | Registered read data |
| ack | output | 1 | Registered configuration-window response |
| fn_sel | output | SUBS | Registered per-sub-board hit on its programmed window |
| cfg_out | output | 1 | Chain enable to the next slot |

## Verification
The bench builds the card with two sub-boards and 64 KB windows. With two sub-boards it can see the chained bit differ between them, see the second sub-board take over the configuration window once the first has its base, and see a shut-up on the last sub-board still drive `cfg_out`. The 64 KB size makes the base compare span all eight upper address lines, so an access one window off from the programmed base shows a miss.

// File: rtl/ac_pkg.sv
package ac_pkg;
  localparam logic [23:0] CFG_WIN   = 24'hE80000;
  localparam int          CFG_LOG2  = 16;
  // word indices (byte offset / 2) of the write registers
  localparam logic [14:0] IDX_BLO   = 15'h0024;
  localparam logic [14:0] IDX_BHI   = 15'h0025;
  localparam logic [14:0] IDX_SHUT  = 15'h0026;
  localparam logic [14:0] IDX_LAST  = 15'h0007;

  function automatic logic [2:0] size_code(input int lg);
    return 3'((lg - 15) & 7);
  endfunction
endpackage

// File: rtl/ac_id_rom.sv
module ac_id_rom #(
  parameter logic [15:0] MAKER    = 16'h0000,
  parameter logic [7:0]  PRODUCT  = 8'h00,
  parameter logic [1:0]  BTYPE    = 2'b11,
  parameter bit          DIAG     = 1'b0,
  parameter bit          SHUT_CAP = 1'b1,
  parameter bit          CHAINED  = 1'b0,
  parameter int          SIZE_LOG2 = 16
) (
  input  logic [14:0] idx,
  output logic [3:0]  nib
);
  localparam logic [2:0] SZ = ac_pkg::size_code(SIZE_LOG2);
  logic [3:0] raw;

  always_comb begin
    case (idx)
      15'd0:   raw = {BTYPE, DIAG, CHAINED};
      15'd1:   raw = {SHUT_CAP, SZ};
      15'd2:   raw = PRODUCT[7:4];
      15'd3:   raw = PRODUCT[3:0];
      15'd4:   raw = MAKER[15:12];
      15'd5:   raw = MAKER[11:8];
      15'd6:   raw = MAKER[7:4];
      15'd7:   raw = MAKER[3:0];
      default: raw = 4'h0;
    endcase
    if (idx == 15'd0)               nib = raw;
    else if (idx > ac_pkg::IDX_LAST) nib = 4'h0;
    else                             nib = ~raw;
  end
endmodule

// File: rtl/ac_slot.sv
module ac_slot #(
  parameter int          ADDR_W    = 24,
  parameter int          SIZE_LOG2 = 16,
  parameter logic [15:0] MAKER     = 16'h0000,
  parameter logic [7:0]  PRODUCT   = 8'h00,
  parameter logic [1:0]  BTYPE     = 2'b11,
  parameter bit          DIAG      = 1'b0,
  parameter bit          SHUT_CAP  = 1'b1,
  parameter bit          CHAINED   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_in,
  input  logic [ADDR_W-1:1] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [3:0]        wnib,
  output logic [3:0]        rnib,
  output logic              ack,
  output logic              fn_sel,
  output logic              chain_out,
  output logic              active
);
  localparam int BASE_W = ADDR_W - ac_pkg::CFG_LOG2;
  localparam logic [ADDR_W-1:0] CFGW = ADDR_W'(ac_pkg::CFG_WIN);

  logic             configured, shut;
  logic [3:0]       base_lo;
  logic [BASE_W-1:0] base;
  logic [14:0]      idx;
  logic [3:0]       rom_nib;
  logic             in_cfg, fn_hit;

  assign idx    = addr[15:1];
  assign in_cfg = addr[ADDR_W-1:16] == CFGW[ADDR_W-1:16];
  assign active = en_in & ~configured & ~shut;
  assign fn_hit = configured &
                  (addr[ADDR_W-1:SIZE_LOG2] == base[BASE_W-1:SIZE_LOG2-16]);

  ac_id_rom #(
    .MAKER(MAKER), .PRODUCT(PRODUCT), .BTYPE(BTYPE), .DIAG(DIAG),
    .SHUT_CAP(SHUT_CAP), .CHAINED(CHAINED), .SIZE_LOG2(SIZE_LOG2)
  ) u_rom (
    .idx(idx),
    .nib(rom_nib)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      configured <= 1'b0;
      shut       <= 1'b0;
      base_lo    <= '0;
      base       <= '0;
      chain_out  <= 1'b0;
      ack        <= 1'b0;
      rnib       <= '0;
      fn_sel     <= 1'b0;
    end else begin
      ack    <= 1'b0;
      rnib   <= '0;
      fn_sel <= 1'b0;
      if (active && in_cfg && rd_stb) begin
        ack  <= 1'b1;
        rnib <= rom_nib;
      end
      if (active && in_cfg && wr_stb) begin
        ack <= 1'b1;
        if (idx == ac_pkg::IDX_BLO) begin
          base_lo <= wnib;
        end else if (idx == ac_pkg::IDX_BHI) begin
          base       <= BASE_W'({wnib, base_lo});
          configured <= 1'b1;
          chain_out  <= 1'b1;
        end else if (idx == ac_pkg::IDX_SHUT && SHUT_CAP) begin
          shut      <= 1'b1;
          chain_out <= 1'b1;
        end
      end
      if (fn_hit && (rd_stb || wr_stb)) fn_sel <= 1'b1;
    end
  end

  // R6
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    chain_out |=> chain_out);
  // R7
  shut_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    shut |=> (!ack && !fn_sel));
  // R5
  base_stable_chk: assert property (@(posedge clk) disable iff (rst)
    configured |=> $stable(base));
  // R1
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !fn_hit) |=> !ack);
endmodule

// File: rtl/expansion_autoconfig.sv
module expansion_autoconfig #(
  parameter int          ADDR_W       = 24,
  parameter int          SUBS         = 2,
  parameter int          SIZE_LOG2    = 16,
  parameter logic [15:0] MAKER        = 16'h1A2B,
  parameter logic [7:0]  PRODUCT_BASE = 8'h40,
  parameter logic [1:0]  BTYPE        = 2'b11,
  parameter bit          DIAG         = 1'b1,
  parameter bit          SHUT_CAP     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_in,
  input  logic [ADDR_W-1:1] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [3:0]        wdata_hi,
  output logic [15:0]       rdata,
  output logic              ack,
  output logic [SUBS-1:0]   fn_sel,
  output logic              cfg_out
);
  logic [SUBS:0]   en;
  logic [SUBS-1:0] acks, act;
  logic [3:0]      nibs [SUBS];
  logic [3:0]      nib_or;

  assign en[0] = cfg_in;

  for (genvar i = 0; i < SUBS; i++) begin : g_sub
    ac_slot #(
      .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2), .MAKER(MAKER),
      .PRODUCT(8'(PRODUCT_BASE + i)), .BTYPE(BTYPE), .DIAG(DIAG),
      .SHUT_CAP(SHUT_CAP), .CHAINED(i < SUBS - 1)
    ) u_slot (
      .clk(clk), .rst(rst), .en_in(en[i]), .addr(addr),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wnib(wdata_hi),
      .rnib(nibs[i]), .ack(acks[i]), .fn_sel(fn_sel[i]),
      .chain_out(en[i+1]), .active(act[i])
    );
  end

  always_comb begin
    nib_or = '0;
    for (int i = 0; i < SUBS; i++) nib_or = nib_or | nibs[i];
  end

  assign rdata   = {nib_or, 12'h000};
  assign ack     = |acks;
  assign cfg_out = en[SUBS];

  // R6
  one_active_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cfg_out && !ack && fn_sel == '0));
endmodule

// File: tb/sim_expansion_autoconfig.sv
module sim_expansion_autoconfig;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_in = 1'b0;
  logic [23:1] addr = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0;
  logic [3:0]  wdata_hi = '0;
  logic [15:0] rdata;
  logic        ack;
  logic [1:0]  fn_sel;
  logic        cfg_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  expansion_autoconfig #(.SUBS(2), .SIZE_LOG2(16), .MAKER(16'h1A2B),
    .PRODUCT_BASE(8'h40), .BTYPE(2'b11), .DIAG(1'b1), .SHUT_CAP(1'b1)) u0 (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .addr(addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wdata_hi(wdata_hi), .rdata(rdata), .ack(ack),
    .fn_sel(fn_sel), .cfg_out(cfg_out));

  // {word index, expected nibble sub-board 0, expected nibble sub-board 1}
  localparam logic [15:0] TBL [9] = '{
    16'h00_FE, 16'h01_66, 16'h02_BB, 16'h03_FE, 16'h04_EE,
    16'h05_55, 16'h06_DD, 16'h07_44, 16'h08_00 };

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // drive on a falling edge, strobe is sampled on the next rising edge,
  // registered result is sampled on the falling edge after it
  task automatic access(input logic [23:0] ba, input bit rd, input bit wr,
                        input logic [3:0] nib);
    @(negedge clk);
    addr = ba[23:1]; rd_stb = rd; wr_stb = wr; wdata_hi = nib;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R8 reset state
    check("R8 cfg_out", cfg_out, 0);
    check("R8 ack", ack, 0);
    check("R8 fn_sel", fn_sel, 0);
    // R1 no enable, no answer
    access(24'hE80000, 1, 0, 0);
    check("R1 ack disabled", ack, 0);
    check("R1 rdata disabled", rdata, 0);

    cfg_in = 1'b1;
    // R2 R3 R10 identity walk, sub-board 0
    for (int k = 0; k < 9; k++) begin
      access(24'hE80000 | (24'(TBL[k][15:8]) << 1), 1, 0, 0);
      check("R2/R10 ack", ack, 1);
      check("R2 R3 R10 nibble s0", rdata, {TBL[k][7:4], 12'h000});
    end
    // R9 latency: result dropped one cycle after strobe
    @(negedge clk);
    check("R9 ack drops", ack, 0);

    // R4 low nibble held only
    access(24'hE80048, 0, 1, 4'h9);
    check("R9 write ack", ack, 1);
    check("R4 cfg_out low", cfg_out, 0);
    access(24'hE80000, 1, 0, 0);
    check("R4 still in config", rdata, 16'hF000);

    // R5 R6 commit base 0xE9
    access(24'hE8004A, 0, 1, 4'hE);
    check("R6 cfg_out not yet (s1 pending)", cfg_out, 0);
    // second sub-board now owns the window
    for (int k = 0; k < 9; k++) begin
      access(24'hE80000 | (24'(TBL[k][15:8]) << 1), 1, 0, 0);
      check("R6 R2 nibble s1", rdata, {TBL[k][3:0], 12'h000});
    end
    access(24'hE90010, 1, 0, 0);
    check("R5 fn_sel hit", fn_sel, 2'b01);
    access(24'hEA0000, 0, 1, 0);
    check("R5 fn_sel miss", fn_sel, 2'b00);

    // R7 shut up last sub-board
    access(24'hE8004C, 0, 1, 0);
    check("R7 cfg_out passed", cfg_out, 1);
    access(24'hE80000, 1, 0, 0);
    check("R7 no answer", ack, 0);
    check("R7 no data", rdata, 0);
    access(24'hE90000, 1, 0, 0);
    check("R7 s0 still decodes", fn_sel, 2'b01);

    // R8 reset clears configuration
    do_reset();
    check("R8 cfg_out cleared", cfg_out, 0);
    access(24'hE90000, 1, 0, 0);
    check("R8 base decode gone", fn_sel, 2'b00);
    access(24'hE80000, 1, 0, 0);
    check("R8 s0 back in window", rdata, 16'hF000);
    // R1 enable removed mid-configuration
    cfg_in = 1'b0;
    access(24'hE80002, 1, 0, 0);
    check("R1 enable low", ack, 0);
    finish_run();
  end
endmodule